// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets an external two-wire (I2C) host read and write a bank of 8-bit configuration registers inside a chip. The bus lines are brought in as plain inputs, synchronised and oversampled by the system clock. The block detects bus conditions, checks the device address and latches a register pointer. It then stores incoming data bytes, or returns register contents when the read follows a repeated START. Its only output on the bus is an open-drain pull-down enable for SDA.

The pointer moves forward by one after every data byte in either direction, so a host can stream a whole range in one transaction. The pointer keeps its value across transactions. A read can therefore either set the pointer in a short write phase and turn around with a repeated START, or simply carry on from where the last access stopped. Other chip logic reads the registers through a separate combinational read port.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset the SDA pull-down is released and every register reads 00h.
- R2: A START (SDA falling while SCL is high) begins address reception from any state, including in the middle of a transfer. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R3: The block answers the 7-bit address 38h (first byte 70h for write, 71h for read) by pulling SDA low throughout the ninth clock.
- R4: For any other address the block does not acknowledge, keeps SDA released and changes no register until the next START or STOP.
- R5: In a write, the byte after the address becomes the register pointer and each later byte is stored at the pointer. The block acknowledges every one of these bytes.
- R6: The pointer advances by one after each data byte, whether written or read, and wraps from FFh to 00h.
- R7: After an address with the R/W bit (bit 0) set to 1, the block drives the register at the pointer MSB first. It changes SDA only while SCL is low.
- R8: A master ACK (SDA low on the ninth clock) makes the block send the next register. A NACK makes it release SDA and stay silent until the next START or STOP.
- R9: The pointer is kept across a STOP, so a read with no pointer phase continues from the last pointer value.
- R10: `cfg_rdata_o` shows, without delay, the register selected by `cfg_raddr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_raddr_i | input | AW (8) | Register index for the chip-side read port |
| cfg_rdata_o | output | 8 | Register contents at `cfg_raddr_i` |

## Verification
A wrong pointer shows up in the very next byte: a stored value lands at a neighbouring index, visible on the chip-side read port, or the wrong register comes back in the following read. A controller that loses its place in the byte, its bit count or its acknowledge slot shows on the bus within one byte time. The master then sees a missing or misplaced ACK, a shifted data byte, or SDA pulled low while SCL is high. The bench compares every acknowledge and data bit on the bus against values it works out itself, and it watches SDA for changes during SCL high for the whole run.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RXBYTE,
        S_ACKSET,
        S_ACKHOLD,
        S_TXBYTE,
        S_TXEND,
        S_MACK,
        S_MACKF,
        S_IGNORE
    } ctrl_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_SUB,
        K_DATA
    } byte_kind_e;

endpackage

// File: rtl/i2c_cfg_cond.sv
module i2c_cfg_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } cond_t;

    cond_t cond_d, cond_q;

    always_comb begin
        cond_d          = cond_q;
        cond_d.scl_sh   = {cond_q.scl_sh[SYNC_STAGES-2:0], scl_i};
        cond_d.sda_sh   = {cond_q.sda_sh[SYNC_STAGES-2:0], sda_i};
        cond_d.scl_prev = cond_q.scl_sh[LAST];
        cond_d.sda_prev = cond_q.sda_sh[LAST];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cond_q <= '1;
        end else begin
            cond_q <= cond_d;
        end
    end

    assign scl_o      = cond_q.scl_sh[LAST];
    assign sda_o      = cond_q.sda_sh[LAST];
    assign scl_rise_o = scl_o && !cond_q.scl_prev;
    assign scl_fall_o = !scl_o && cond_q.scl_prev;
    assign start_o    = scl_o && cond_q.scl_prev && cond_q.sda_prev && !sda_o;
    assign stop_o     = scl_o && cond_q.scl_prev && !cond_q.sda_prev && sda_o;

    AST_COND_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o})); // R2

endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] bus_raddr_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic [AW-1:0] cfg_raddr_i,
    output logic [DW-1:0] cfg_rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            mem_d[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign bus_rdata_o = mem_q[bus_raddr_i];
    assign cfg_rdata_o = mem_q[cfg_raddr_i];

    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (mem_q[$past(wr_addr_i)] == $past(wr_data_i))); // R5

endmodule

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
    import i2c_cfg_pkg::*;
#(
    parameter int         AW       = 8,
    parameter logic [6:0] DEV_ADDR = 7'h38
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i
);

    typedef struct packed {
        ctrl_state_e       st;
        byte_kind_e        kind;
        logic [2:0]        cnt;
        logic [BYTE_W-1:0] rxsh;
        logic [BYTE_W-1:0] txb;
        logic [AW-1:0]     ptr;
        logic              rw;
        logic              oe;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d  = ctrl_q;
        wr_en_o = 1'b0;
        if (stop_i) begin
            ctrl_d.st = S_IDLE;
            ctrl_d.oe = 1'b0;
        end else if (start_i) begin
            ctrl_d.st   = S_RXBYTE;
            ctrl_d.kind = K_ADDR;
            ctrl_d.cnt  = '0;
            ctrl_d.rw   = 1'b0;
            ctrl_d.oe   = 1'b0;
        end else begin
            unique case (ctrl_q.st)
                S_IDLE, S_IGNORE: begin
                    ctrl_d.oe = 1'b0;
                end
                S_RXBYTE: begin
                    if (rise_i) begin
                        ctrl_d.rxsh = {ctrl_q.rxsh[BYTE_W-2:0], sda_i};
                        ctrl_d.cnt  = ctrl_q.cnt + 3'd1;
                        if (ctrl_q.cnt == 3'd7) begin
                            ctrl_d.st = S_ACKSET;
                        end
                    end
                end
                S_ACKSET: begin
                    if (fall_i) begin
                        ctrl_d.oe = 1'b1;
                        ctrl_d.st = S_ACKHOLD;
                        unique case (ctrl_q.kind)
                            K_ADDR: begin
                                if (ctrl_q.rxsh[7:1] == DEV_ADDR) begin
                                    ctrl_d.rw   = ctrl_q.rxsh[0];
                                    ctrl_d.kind = K_SUB;
                                end else begin
                                    ctrl_d.oe = 1'b0;
                                    ctrl_d.st = S_IGNORE;
                                end
                            end
                            K_SUB: begin
                                ctrl_d.ptr  = ctrl_q.rxsh[AW-1:0];
                                ctrl_d.kind = K_DATA;
                            end
                            default: begin
                                wr_en_o    = 1'b1;
                                ctrl_d.ptr = ctrl_q.ptr + 1'b1;
                            end
                        endcase
                    end
                end
                S_ACKHOLD, S_MACKF: begin
                    if (fall_i) begin
                        ctrl_d.cnt = '0;
                        if (ctrl_q.rw) begin
                            ctrl_d.txb = rd_data_i;
                            ctrl_d.oe  = ~rd_data_i[BYTE_W-1];
                            ctrl_d.ptr = ctrl_q.ptr + 1'b1;
                            ctrl_d.st  = S_TXBYTE;
                        end else begin
                            ctrl_d.oe = 1'b0;
                            ctrl_d.st = S_RXBYTE;
                        end
                    end
                end
                S_TXBYTE: begin
                    if (rise_i) begin
                        if (ctrl_q.cnt == 3'd7) begin
                            ctrl_d.st = S_TXEND;
                        end else begin
                            ctrl_d.cnt = ctrl_q.cnt + 3'd1;
                        end
                    end else if (fall_i) begin
                        ctrl_d.oe = ~ctrl_q.txb[~ctrl_q.cnt];
                    end
                end
                S_TXEND: begin
                    if (fall_i) begin
                        ctrl_d.oe = 1'b0;
                        ctrl_d.st = S_MACK;
                    end
                end
                S_MACK: begin
                    if (rise_i) begin
                        ctrl_d.st = sda_i ? S_IGNORE : S_MACKF;
                    end
                end
                default: begin
                    ctrl_d.st = S_IDLE;
                    ctrl_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q      <= '0;
            ctrl_q.st   <= S_IDLE;
            ctrl_q.kind <= K_ADDR;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign sda_oe_o  = ctrl_q.oe;
    assign wr_addr_o = ctrl_q.ptr;
    assign wr_data_o = ctrl_q.rxsh;
    assign rd_addr_o = ctrl_q.ptr;

    AST_SDA_MOVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ctrl_q.oe) |-> !scl_i); // R7

    AST_IGNORE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.st == S_IGNORE) |-> !ctrl_q.oe); // R4

    AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (ctrl_q.st == S_IDLE && !ctrl_q.oe)); // R2

    AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !stop_i) |=> (ctrl_q.st == S_RXBYTE && ctrl_q.kind == K_ADDR && ctrl_q.cnt == 3'd0)); // R2

    AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |=> (ctrl_q.ptr == $past(ctrl_q.ptr) + 1'b1)); // R6

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h38
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [AW-1:0]     cfg_raddr_i,
    output logic [BYTE_W-1:0] cfg_rdata_o
);

    logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic              wr_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    i2c_cfg_cond #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_cond (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (bus_start),
        .stop_o    (bus_stop)
    );

    i2c_cfg_ctrl #(
        .AW      (AW),
        .DEV_ADDR(DEV_ADDR)
    ) i_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .scl_i    (scl_s),
        .sda_i    (sda_s),
        .rise_i   (scl_rise),
        .fall_i   (scl_fall),
        .start_i  (bus_start),
        .stop_i   (bus_stop),
        .sda_oe_o (sda_oe_o),
        .wr_en_o  (wr_en),
        .wr_addr_o(wr_addr),
        .wr_data_o(wr_data),
        .rd_addr_o(rd_addr),
        .rd_data_i(rd_data)
    );

    i2c_cfg_regs #(
        .AW(AW),
        .DW(BYTE_W)
    ) i_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .bus_raddr_i(rd_addr),
        .bus_rdata_o(rd_data),
        .cfg_raddr_i(cfg_raddr_i),
        .cfg_rdata_o(cfg_rdata_o)
    );

endmodule

// File: tb/test_i2c_cfg_slave.sv
module test_i2c_cfg_slave;

    localparam int H = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_oe;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_data;
    logic       sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int hi_moves = 0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = ~(m_low | sda_oe);

    i2c_cfg_slave i_i2c_cfg_slave (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .cfg_raddr_i(cfg_addr),
        .cfg_rdata_o(cfg_data)
    );

    always @(negedge clk) begin
        if (rst_n && scl && (sda_oe != oe_prev)) hi_moves++;
        oe_prev = sda_oe;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_w(input logic b);
        m_low = ~b; wt(H); scl = 1'b1; wt(H); scl = 1'b0;
    endtask

    task automatic bit_r(output logic s);
        m_low = 1'b0; wt(H); scl = 1'b1; wt(H / 2); s = sda_bus; wt(H / 2); scl = 1'b0;
    endtask

    task automatic start_c();
        m_low = 1'b0; scl = 1'b1; wt(H); m_low = 1'b1; wt(H); scl = 1'b0;
    endtask

    task automatic rstart_c();
        m_low = 1'b0; wt(H); scl = 1'b1; wt(H); m_low = 1'b1; wt(H); scl = 1'b0;
    endtask

    task automatic stop_c();
        m_low = 1'b1; wt(H); scl = 1'b1; wt(H); m_low = 1'b0; wt(H);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_w(b[i]);
        bit_r(s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_r(s);
            b[i] = s;
        end
        bit_w(~give_ack);
    endtask

    task automatic cfg_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        cfg_addr = a; wt(1);
        chk(cfg_data == exp, req, cfg_data, exp);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
        cfg_chk(8'h00, 8'h00, "R1 reg00");
        cfg_chk(8'h10, 8'h00, "R10 reg10");
        cfg_chk(8'hFF, 8'h00, "R1 regFF");
    endtask

    task automatic t_write_burst();
        logic a;
        start_c();
        wbyte(8'h70, a); chk(a, "R3 addr ack", a, 1);
        wbyte(8'h10, a); chk(a, "R5 sub ack", a, 1);
        wbyte(8'hA5, a); chk(a, "R5 data ack", a, 1);
        wbyte(8'h3C, a); chk(a, "R5 data ack", a, 1);
        wbyte(8'h7E, a); chk(a, "R5 data ack", a, 1);
        stop_c();
        cfg_chk(8'h10, 8'hA5, "R5 reg10");
        cfg_chk(8'h11, 8'h3C, "R6 reg11");
        cfg_chk(8'h12, 8'h7E, "R6 reg12");
        cfg_chk(8'h13, 8'h00, "R10 reg13");
    endtask

    task automatic t_wrong_addr();
        logic a;
        start_c();
        wbyte(8'h72, a); chk(!a, "R4 no ack", a, 0);
        wbyte(8'h10, a); chk(!a, "R4 sub ignored", a, 0);
        wbyte(8'hFF, a); chk(!a, "R4 data ignored", a, 0);
        chk(sda_oe == 1'b0, "R4 released", sda_oe, 0);
        stop_c();
        cfg_chk(8'h10, 8'hA5, "R4 reg10 kept");
    endtask

    task automatic t_combined_read();
        logic a;
        logic [7:0] d;
        start_c();
        wbyte(8'h70, a); chk(a, "R3 addr ack", a, 1);
        wbyte(8'h10, a); chk(a, "R5 sub ack", a, 1);
        rstart_c();
        wbyte(8'h71, a); chk(a, "R3 read addr ack", a, 1);
        rbyte(1'b1, d); chk(d == 8'hA5, "R7 byte0", d, 8'hA5);
        rbyte(1'b1, d); chk(d == 8'h3C, "R8 byte1", d, 8'h3C);
        rbyte(1'b0, d); chk(d == 8'h7E, "R6 byte2", d, 8'h7E);
        rbyte(1'b0, d); chk(d == 8'hFF, "R8 silent after nack", d, 8'hFF);
        stop_c();
    endtask

    task automatic t_wrap();
        logic a;
        start_c();
        wbyte(8'h70, a); chk(a, "R3 addr ack", a, 1);
        wbyte(8'hFE, a);
        wbyte(8'h11, a);
        wbyte(8'h22, a);
        wbyte(8'h33, a); chk(a, "R6 ack after wrap", a, 1);
        stop_c();
        cfg_chk(8'hFE, 8'h11, "R6 regFE");
        cfg_chk(8'hFF, 8'h22, "R6 regFF");
        cfg_chk(8'h00, 8'h33, "R6 wrap reg00");
    endtask

    task automatic t_pointer_kept();
        logic a;
        logic [7:0] d;
        start_c();
        wbyte(8'h70, a); wbyte(8'h20, a); wbyte(8'h99, a); wbyte(8'h66, a);
        stop_c();
        start_c();
        wbyte(8'h70, a); wbyte(8'h21, a); chk(a, "R9 sub ack", a, 1);
        stop_c();
        start_c();
        wbyte(8'h71, a); chk(a, "R9 read addr ack", a, 1);
        rbyte(1'b0, d); chk(d == 8'h66, "R9 read after stop", d, 8'h66);
        stop_c();
    endtask

    task automatic t_restart_write();
        logic a;
        start_c();
        wbyte(8'h70, a); wbyte(8'h30, a); wbyte(8'h12, a);
        rstart_c();
        wbyte(8'h70, a); chk(a, "R2 ack after restart", a, 1);
        wbyte(8'h31, a); wbyte(8'h34, a);
        stop_c();
        chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
        cfg_chk(8'h30, 8'h12, "R2 reg30");
        cfg_chk(8'h31, 8'h34, "R2 reg31");
        cfg_chk(8'h32, 8'h00, "R2 reg32 untouched");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wt(10);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_write_burst();
        t_wrong_addr();
        t_combined_read();
        t_wrap();
        t_pointer_kept();
        t_restart_write();
        chk(hi_moves == 0, "R7 SDA steady while SCL high", hi_moves, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule